// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz clock-enable tick into a periodic event at a rate picked by a 4-bit rate code. Each time the selected period elapses, it sets a sticky periodic flag. The flag stays set until the host strobes a clear. The interrupt request is the flag gated by an enable bit.

The rate code is not linear:

- Code 0 stops the events.
- Codes 1 and 2 behave as codes 8 and 9.
- Codes 3 through 15 halve the rate at each step, from 8192 Hz (4 ticks) down to 2 Hz (16384 ticks). The usual setting, code 6, gives 1024 Hz (32 ticks).

A 3-bit divider-control field holds the divider at zero while it carries the pattern 111. A new rate code is picked up only when the divider wraps, so changing the code never shortens a period or produces an extra event.

Top module: `pit_rate_gen`

## Requirements
- R1: With rate code 0 in force, no event is produced and `flag_o` stays 0.
- R2: Rate code c (3 to 15) gives an event every 2^(c-1) ticks: code 3 gives every 4th tick, code 6 every 32nd and code 15 every 16384th. The first event after the divider starts comes on the 2^(c-1)-th counted tick.
- R3: Rate code 1 has the period of code 8 (128 ticks) and code 2 has the period of code 9 (256 ticks).
- R4: Only clock edges with `tick_i` high advance the divider. Edges with `tick_i` low are ignored.
- R5: While `div_ctl_i` equals 3'b111, the divider is held at zero and no event occurs. After release, the first event follows a full period.
- R6: An event sets `flag_o` at the clock edge of the terminal tick. `flag_o` then stays 1 until an edge with `flag_clr_i` high and no event clears it.
- R7: When an event and `flag_clr_i` fall on the same edge, `flag_o` is 1 after that edge.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R9: A rate-code change takes effect at the next divider wrap. The current period completes at the old rate with no extra event. A change to code 0 stops events after that wrap.
- R10: After reset, `flag_o` and `irq_o` are 0 and the divider starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32768 Hz clock-enable tick |
| rate_sel_i | input | 4 | Rate code |
| div_ctl_i | input | 3 | Divider control; 3'b111 holds the divider at zero |
| flag_clr_i | input | 1 | Host clear strobe for the periodic flag |
| irq_en_i | input | 1 | Periodic interrupt enable |
| flag_o | output | 1 | Sticky periodic flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on one clock edge: the divider reaching its terminal count, and the host clearing the flag.

The bench provokes this by driving `flag_clr_i` so that it is sampled on the exact edge where a known 4-tick period ends. It then expects `flag_o` still set after that edge. It also expects a clear on the following, event-free edge to drop both `flag_o` and `irq_o`.

A second coincidence is a rate change arriving mid-period. It is judged by the exact cycle of each later flag rise, which the scoreboard checks.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int RATE_W    = 4;
  localparam int CTL_W     = 3;
  localparam int MAX_SHIFT = (1 << RATE_W) - 2;
  localparam int DIV_W     = MAX_SHIFT;
  localparam logic [CTL_W-1:0] HOLD_PAT = '1;

  // log2 of the period in ticks; aliases for the two low codes
  function automatic int rate_shift(input logic [RATE_W-1:0] code);
    int sh;
    if (code == RATE_W'(1))      sh = 7;
    else if (code == RATE_W'(2)) sh = 8;
    else                         sh = int'(code) - 1;
    return sh;
  endfunction

  function automatic logic [DIV_W-1:0] rate_term(input logic [RATE_W-1:0] code);
    logic [DIV_W:0] t;
    t = ({{DIV_W{1'b0}}, 1'b1} << rate_shift(code)) - 1'b1;
    return t[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
  import pit_pkg::*;
(
  input  logic [RATE_W-1:0] code_i,
  output logic              en_o,
  output logic [DIV_W-1:0]  term_o
);
  assign en_o   = (code_i != '0);
  assign term_o = en_o ? rate_term(code_i) : '0;
endmodule

// File: rtl/pit_divider.sv
module pit_divider
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] code_i,
  input  logic [CTL_W-1:0]  div_ctl_i,
  output logic              ev_o
);
  logic [RATE_W-1:0] act_q, eff_code;
  logic [DIV_W-1:0]  cnt_q, term;
  logic              hold, run_en, at_term;

  assign hold     = (div_ctl_i == HOLD_PAT);
  // idle divider follows the live code; running one keeps its code to the wrap
  assign eff_code = (act_q == '0) ? code_i : act_q;

  pit_rate_decode u_dec (
    .code_i (eff_code),
    .en_o   (run_en),
    .term_o (term)
  );

  assign at_term = (cnt_q == term);
  assign ev_o    = tick_i & ~hold & run_en & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (hold) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (tick_i) begin
      if (!run_en) begin
        cnt_q <= '0;
        act_q <= '0;
      end else if (at_term) begin
        cnt_q <= '0;
        act_q <= code_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        act_q <= eff_code;
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != '0) |-> (cnt_q <= term));
  a_r2_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> !ev_o);
  a_r5_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (cnt_q == '0) && !ev_o);
  a_r9_wrap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> (act_q == $past(code_i)));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0 && code_i == '0) |-> !ev_o);
endmodule

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (ev_i)   flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> flag_q);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev_i) |=> !flag_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/pit_rate_gen.sv
module pit_rate_gen
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic [CTL_W-1:0]  div_ctl_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic ev;

  pit_divider u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .code_i    (rate_sel_i),
    .div_ctl_i (div_ctl_i),
    .ev_o      (ev)
  );

  pit_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o & irq_en_i;

  a_r6_rise_has_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(ev));
  a_r5_no_event_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_ctl_i == HOLD_PAT) |-> !ev);
endmodule

// File: tb/pit_rate_gen_tb.sv
module pit_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic [3:0] rate_sel_i = 4'd0;
  logic [2:0] div_ctl_i = 3'b111;
  logic       irq_en_i = 1'b0;
  logic       mon_clr = 1'b0, man_clr = 1'b0;
  logic       flag_o, irq_o;
  logic       tick_alt = 1'b0;
  logic       mon_on = 1'b0;
  int         cyc = 0;
  int         checks = 0, errors = 0;
  int         exp_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_i = tick_alt ? cyc[0] : 1'b1;

  pit_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rate_sel_i(rate_sel_i),
    .div_ctl_i(div_ctl_i), .flag_clr_i(mon_clr | man_clr), .irq_en_i(irq_en_i),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: every flag rise must match the head of the expected queue
  always @(negedge clk) begin
    mon_clr <= 1'b0;
    if (mon_on && flag_o) begin
      if (exp_q.size() == 0) begin
        chk("R1/R5/R9 spurious event", 1, 0);
      end else begin
        chk("R2/R3/R9 event cycle", cyc, exp_q.pop_front());
      end
      mon_clr <= 1'b1;
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // hold, release, push expected event cycles, wait for them
  task automatic run_code(input logic [3:0] code, input int per, input int n);
    int c0;
    div_ctl_i = 3'b111;
    rate_sel_i = code;
    repeat (3) @(negedge clk);
    div_ctl_i = 3'b010;
    c0 = cyc + 1;
    for (int k = 0; k < n; k++) exp_q.push_back(c0 + per - 1 + k * per);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    div_ctl_i = 3'b111;
    @(negedge clk);
  endtask

  initial begin
    int c0, t;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 flag after reset", flag_o, 0);
    chk("R10 irq after reset", irq_o, 0);
    mon_on = 1'b1;

    run_code(4'd3, 4, 3);       // R2 fastest
    run_code(4'd6, 32, 2);      // R2 default code
    run_code(4'd9, 256, 1);     // R2
    run_code(4'd1, 128, 2);     // R3 alias of 8
    run_code(4'd2, 256, 2);     // R3 alias of 9
    run_code(4'd15, 16384, 1);  // R2 slowest

    // R1: code 0 silent
    rate_sel_i = 4'd0;
    div_ctl_i = 3'b010;
    repeat (300) @(negedge clk);
    chk("R1 code 0 flag", flag_o, 0);

    // R5: hold with code 3 produces nothing
    div_ctl_i = 3'b111;
    rate_sel_i = 4'd3;
    repeat (60) @(negedge clk);
    chk("R5 held divider flag", flag_o, 0);

    // R9: change 3 -> 4 mid-period
    div_ctl_i = 3'b010;
    c0 = cyc + 1;
    exp_q.push_back(c0 + 3); exp_q.push_back(c0 + 7);
    exp_q.push_back(c0 + 15); exp_q.push_back(c0 + 23);
    wait_cyc(c0 + 5);
    rate_sel_i = 4'd4;
    while (exp_q.size() != 0) @(negedge clk);
    // R9: change to 0 stops after the wrap
    div_ctl_i = 3'b111;
    rate_sel_i = 4'd3;
    repeat (2) @(negedge clk);
    div_ctl_i = 3'b010;
    c0 = cyc + 1;
    exp_q.push_back(c0 + 3); exp_q.push_back(c0 + 7);
    wait_cyc(c0 + 5);
    rate_sel_i = 4'd0;
    repeat (100) @(negedge clk);
    chk("R9 queue drained after stop", exp_q.size(), 0);
    chk("R9 no flag after stop", flag_o, 0);
    mon_on = 1'b0;

    // R4: tick on alternate edges
    div_ctl_i = 3'b111;
    rate_sel_i = 4'd3;
    repeat (2) @(negedge clk);
    tick_alt = 1'b1;
    @(negedge clk);
    div_ctl_i = 3'b010;
    t = 0;
    while (1) begin
      if (tick_i) t++;
      if (t == 4) break;
      @(negedge clk);
      if (flag_o) chk("R4 early event", 1, 0);
    end
    @(negedge clk);
    chk("R4 event on fourth tick", flag_o, 1);
    tick_alt = 1'b0;

    // R6/R7/R8
    div_ctl_i = 3'b111;
    man_clr = 1'b1;
    @(negedge clk);
    man_clr = 1'b0;
    div_ctl_i = 3'b010;
    c0 = cyc + 1;
    wait_cyc(c0 + 3);
    chk("R6 flag set", flag_o, 1);
    chk("R8 irq gated off", irq_o, 0);
    wait_cyc(c0 + 9);
    chk("R6 flag sticky", flag_o, 1);
    irq_en_i = 1'b1;
    #1 chk("R8 irq on", irq_o, 1);
    wait_cyc(c0 + 10);
    man_clr = 1'b1;               // sampled at the event edge c0+11
    @(negedge clk);
    man_clr = 1'b0;
    chk("R7 set beats clear", flag_o, 1);
    man_clr = 1'b1;               // sampled at c0+12, no event
    @(negedge clk);
    man_clr = 1'b0;
    chk("R6 clear", flag_o, 0);
    chk("R8 irq follows clear", irq_o, 0);
    div_ctl_i = 3'b111;
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule